// File: doc/BRIEF.md
# Daisy-Chained ADC Serial Readout Controller

This block sits on the host side of a string of serial delta-sigma converters. In the string, each converter's primary data output is wired into the chain input of its neighbour. The converter at the far end has its chain input tied low, and the converter nearest the host drives the host's data line. Once per output-data period the controller runs a shared serial clock. It shifts in every 24-bit channel word of the whole string and hands each word out in parallel with its channel index.

A 3-bit protocol code picks how a readout starts. In the SPI-style codes, a falling edge on the data-ready line of one converter starts a readout; all converters share one sync, so one line is enough. In the frame-sync codes, the controller raises its own frame pulse at a programmable period, and the converters present fresh data from that rising edge onward. The string can be split into two segments that share the clock and are captured in parallel on separate data lines. If a new start event arrives while a readout is still running, the controller flags an overrun.

Top module: `adc_chain_reader`

## Requirements
- R1: Protocol codes 000 and 001 select data-ready starts and codes 011 and 100 select frame-sync starts. With any other code no readout starts, `fsync` stays low and `sclk` does not toggle, even when `drdy_n` falls.
- R2: In the data-ready protocol, a high-to-low transition of `drdy_n` (active low) while idle starts one readout, and `fsync` stays low.
- R3: In the frame-sync protocol, `fsync` rises once every `frame_cyc` clock cycles and stays high for exactly 2*CLK_DIV cycles, and the readout begins after it falls.
- R4: `sclk` is low at reset, between readouts and whenever `fsync` is high. During a readout it stays high for CLK_DIV clock cycles per period and produces exactly 24 times the segment channel count (384 by default) rising edges.
- R5: The data inputs are sampled on `sclk` rising edges. Each word is 24 bits, MSB first. Words come out in chain order, nearest device's channel 0 first, with `word_ch` running from 0 to the segment channel count minus one.
- R6: With two segments, both lanes raise their `word_vld` bit in the same cycle for the same `word_ch`. Each lane carries the word of its own data input in `word_data` (lane s in bits 24*s+23 down to 24*s).
- R7: A start event that arrives during a frame pulse or a readout makes `overrun` high for one cycle per event. The event is otherwise discarded, and the readout in progress completes unchanged.
- R8: The segment channel count is checked at elaboration against the limit of the selected speed mode: 10 for high-speed, 21 for high-resolution, 21 or 10 for low-power (divider 1 or 0), and 106 or 21 for low-speed (divider 1 or 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Protocol code |
| drdy_n | input | 1 | Data-ready from the monitored converter, active low |
| frame_cyc | input | FRAME_W | Frame period in clock cycles (frame-sync protocol) |
| sdi | input | NUM_SEG | Serial data from the nearest converter of each segment |
| sclk | output | 1 | Shared serial clock, idles low |
| fsync | output | 1 | Frame pulse |
| word_vld | output | NUM_SEG | Per-lane word strobe |
| word_data | output | NUM_SEG*WORD_W | Per-lane received word |
| word_ch | output | CH_W | Channel index of the current words |
| overrun | output | 1 | Start event rejected while busy |

## Verification
A start event can land in the same stretch of cycles as an active shift: a second `drdy_n` fall while the serial clock is running, or a frame period set shorter than the readout so that the frame timer wraps mid-shift. The bench provokes both cases. It then judges that exactly one overrun pulse appears per rejected event, that no extra frame pulse or reload follows, and that every word of the original readout still arrives in order with the right index. In both lanes, each word is compared against a behavioural model of the chained shift registers.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [2:0] {
        SPD_HIGH,
        SPD_HIRES,
        SPD_LOWPWR_DIV1,
        SPD_LOWPWR_DIV0,
        SPD_LOWSPD_DIV1,
        SPD_LOWSPD_DIV0
    } speed_e;

    typedef enum logic [1:0] {
        PROTO_NONE,
        PROTO_SPI,
        PROTO_FRAME
    } proto_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_SHIFT
    } rd_state_e;

    // serial clock state plus its edge strobes for the current cycle
    typedef struct packed {
        logic rise;
        logic fall;
        logic sclk;
    } sclk_ev_t;

    // longest chain that fits in one data period at sclk == master clock
    function automatic int max_chain_ch(speed_e m);
        case (m)
            SPD_HIGH:        return 10;
            SPD_HIRES:       return 21;
            SPD_LOWPWR_DIV1: return 21;
            SPD_LOWPWR_DIV0: return 10;
            SPD_LOWSPD_DIV1: return 106;
            SPD_LOWSPD_DIV0: return 21;
            default:         return 0;
        endcase
    endfunction

    function automatic proto_e decode_proto(logic [2:0] code);
        case (code)
            3'b000, 3'b001: return PROTO_SPI;
            3'b011, 3'b100: return PROTO_FRAME;
            default:        return PROTO_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dcr_sclk_gen.sv
module dcr_sclk_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output dcr_pkg::sclk_ev_t ev
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic             sclk_q;
    logic             tick;

    assign tick = en && (cnt == CNT_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign ev.rise = tick & ~sclk_q;
    assign ev.fall = tick & sclk_q;
    assign ev.sclk = sclk_q;

endmodule

// File: rtl/dcr_trigger.sv
module dcr_trigger #(
    parameter int FRAME_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  dcr_pkg::proto_e     proto,
    input  logic                drdy_n,
    input  logic [FRAME_W-1:0]  frame_cyc,
    output logic                evt
);
    import dcr_pkg::*;

    logic               drdy_q;
    logic [FRAME_W-1:0] ftmr;
    logic               frame_wrap;
    logic               drdy_fall;

    assign frame_wrap = (proto == PROTO_FRAME) && (ftmr == frame_cyc - 1'b1);
    assign drdy_fall  = (proto == PROTO_SPI) && drdy_q && !drdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            drdy_q <= 1'b1;
            ftmr   <= '0;
            evt    <= 1'b0;
        end else begin
            drdy_q <= drdy_n;
            ftmr   <= (proto != PROTO_FRAME || frame_wrap) ? '0 : ftmr + 1'b1;
            evt    <= drdy_fall || frame_wrap;
        end
    end

endmodule

// File: rtl/dcr_lane.sv
module dcr_lane #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              take,
    input  logic              last,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-2:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= take && last;
            if (take) begin
                acc <= {acc[WORD_W-3:0], sdi};
            end
            if (take && last) begin
                word <= {acc, sdi};
            end
        end
    end

    // R5
    vld_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader #(
    parameter int              WORD_W       = 24,
    parameter int              CH_PER_DEV   = 8,
    parameter int              DEVS_PER_SEG = 2,
    parameter int              NUM_SEG      = 2,
    parameter int              CLK_DIV      = 2,
    parameter int              FRAME_W      = 16,
    parameter dcr_pkg::speed_e SPEED        = dcr_pkg::SPD_HIRES,
    localparam int             SEG_CH       = CH_PER_DEV * DEVS_PER_SEG,
    localparam int             CH_W         = (SEG_CH > 1) ? $clog2(SEG_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                fmt,
    input  logic                      drdy_n,
    input  logic [FRAME_W-1:0]        frame_cyc,
    input  logic [NUM_SEG-1:0]        sdi,
    output logic                      sclk,
    output logic                      fsync,
    output logic [NUM_SEG-1:0]        word_vld,
    output logic [NUM_SEG*WORD_W-1:0] word_data,
    output logic [CH_W-1:0]           word_ch,
    output logic                      overrun
);
    import dcr_pkg::*;

    localparam int BIT_W  = $clog2(WORD_W);
    localparam int FS_LEN = 2 * CLK_DIV;
    localparam int FS_W   = $clog2(FS_LEN + 1);

    // R8: chain length must fit the data period of the selected mode
    if (SEG_CH > max_chain_ch(SPEED)) begin : g_chain_too_long
        $error("segment channel count exceeds the limit of the speed mode");
    end

    proto_e     proto;
    logic       evt;
    rd_state_e  state;
    sclk_ev_t   sev;
    logic [FS_W-1:0]  fs_cnt;
    logic             fsync_q;
    logic [BIT_W-1:0] bpos;
    logic [CH_W-1:0]  chn;
    logic [CH_W-1:0]  ch_q;
    logic             done_q;
    logic             ovr_q;
    logic             word_end;
    logic             chain_end;

    assign proto = decode_proto(fmt);

    dcr_trigger #(.FRAME_W(FRAME_W)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .proto     (proto),
        .drdy_n    (drdy_n),
        .frame_cyc (frame_cyc),
        .evt       (evt)
    );

    dcr_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk (clk),
        .rst (rst),
        .en  (state == ST_SHIFT),
        .ev  (sev)
    );

    assign word_end  = (bpos == BIT_W'(WORD_W - 1));
    assign chain_end = word_end && (chn == CH_W'(SEG_CH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            fs_cnt  <= '0;
            fsync_q <= 1'b0;
            bpos    <= '0;
            chn     <= '0;
            ch_q    <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            ovr_q <= evt && (state != ST_IDLE);
            case (state)
                ST_IDLE: begin
                    if (evt) begin
                        bpos   <= '0;
                        chn    <= '0;
                        done_q <= 1'b0;
                        if (proto == PROTO_FRAME) begin
                            state   <= ST_FRAME;
                            fsync_q <= 1'b1;
                            fs_cnt  <= '0;
                        end else begin
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_FRAME: begin
                    if (fs_cnt == FS_W'(FS_LEN - 1)) begin
                        state   <= ST_SHIFT;
                        fsync_q <= 1'b0;
                    end else begin
                        fs_cnt <= fs_cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (sev.rise) begin
                        if (word_end) begin
                            bpos <= '0;
                            ch_q <= chn;
                            if (chain_end) begin
                                done_q <= 1'b1;
                            end else begin
                                chn <= chn + 1'b1;
                            end
                        end else begin
                            bpos <= bpos + 1'b1;
                        end
                    end
                    if (sev.fall && done_q) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_lane
        dcr_lane #(.WORD_W(WORD_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sdi      (sdi[s]),
            .take     (sev.rise),
            .last     (word_end),
            .word_vld (word_vld[s]),
            .word     (word_data[s*WORD_W +: WORD_W])
        );
    end

    assign sclk    = sev.sclk;
    assign fsync   = fsync_q;
    assign word_ch = ch_q;
    assign overrun = ovr_q;

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SHIFT) |-> !sclk);

    // R4
    fsync_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fsync && sclk));

    // R3
    fsync_proto_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> ($past(proto) == PROTO_FRAME));

    // R5
    word_sclk_chk: assert property (@(posedge clk) disable iff (rst)
        (|word_vld) |-> sclk);

endmodule

// File: tb/adc_chain_reader_tb.sv
module adc_chain_reader_tb;
    import dcr_pkg::*;

    localparam int WORD_W   = 24;
    localparam int CH_PER   = 8;
    localparam int DEVS     = 2;
    localparam int NSEG     = 2;
    localparam int CLK_DIV  = 2;
    localparam int SEG_CH   = CH_PER * DEVS;
    localparam int SEG_BITS = SEG_CH * WORD_W;
    localparam int CH_W     = $clog2(SEG_CH);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [2:0]              fmt = 3'b111;
    logic                    drdy_n = 1'b1;
    logic [15:0]             frame_cyc = 16'd1800;
    logic [NSEG-1:0]         sdi;
    wire                     sclk, fsync, overrun;
    wire [NSEG-1:0]          word_vld;
    wire [NSEG*WORD_W-1:0]   word_data;
    wire [CH_W-1:0]          word_ch;

    always #10 clk = ~clk;

    adc_chain_reader #(
        .WORD_W(WORD_W), .CH_PER_DEV(CH_PER), .DEVS_PER_SEG(DEVS),
        .NUM_SEG(NSEG), .CLK_DIV(CLK_DIV), .FRAME_W(16)
    ) u_dut (
        .clk(clk), .rst(rst), .fmt(fmt), .drdy_n(drdy_n), .frame_cyc(frame_cyc),
        .sdi(sdi), .sclk(sclk), .fsync(fsync), .word_vld(word_vld),
        .word_data(word_data), .word_ch(word_ch), .overrun(overrun)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    task automatic chk(string req, bit ok, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // behavioural chain model: shift on falling sclk, far input tied low
    logic spi_ld = 1'b0;
    wire  ld = spi_ld | fsync;
    logic [SEG_BITS-1:0] dev_sr [NSEG] = '{default: '0};
    logic [31:0] exp_q [NSEG][$];
    int seed = 0;

    function automatic logic [WORD_W-1:0] gen_word(int sd, int s, int ch);
        logic [31:0] h;
        if (sd % 2 == 0 && ch == 0) return 24'h800000;
        if (sd % 2 == 0 && ch == SEG_CH - 1) return 24'h7FFFFF;
        h = 32'(sd) * 32'h9E3779B1 + 32'(s) * 32'h85EBCA77 + 32'(ch) * 32'hC2B2AE3D;
        h = h ^ (h >> 15);
        return h[WORD_W-1:0];
    endfunction

    always @(negedge sclk or posedge ld) begin
        if (ld) begin
            for (int s = 0; s < NSEG; s++) begin
                for (int ch = 0; ch < SEG_CH; ch++) begin
                    logic [WORD_W-1:0] w;
                    w = gen_word(seed, s, ch);
                    dev_sr[s][SEG_BITS-1-ch*WORD_W -: WORD_W] = w;
                    exp_q[s].push_back({8'(ch), w});
                end
            end
            seed++;
        end else begin
            for (int s = 0; s < NSEG; s++)
                dev_sr[s] = {dev_sr[s][SEG_BITS-2:0], 1'b0};
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_sdi
        assign sdi[s] = dev_sr[s][SEG_BITS-1];
    end

    // event counters
    int cyc = 0;
    int sclk_rises = 0;
    int fs_rises = 0;
    int fs_last = 0;
    int fs_gap = 0;
    int ovr_seen = 0;
    int words_seen = 0;
    int hi_run = 0;
    int fs_run = 0;

    always @(posedge sclk) sclk_rises++;
    always @(posedge fsync) begin
        fs_rises++;
        fs_gap  = cyc - fs_last;
        fs_last = cyc;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (sclk) hi_run++;
            else if (hi_run != 0) begin
                chk("R4 sclk high time", hi_run == CLK_DIV, hi_run, CLK_DIV);
                hi_run = 0;
            end
            if (fsync) fs_run++;
            else if (fs_run != 0) begin
                chk("R3 fsync width", fs_run == 2 * CLK_DIV, fs_run, 2 * CLK_DIV);
                fs_run = 0;
            end
            if (fsync && sclk) chk("R4 sclk low during fsync", 1'b0, 1, 0);
            if (overrun) ovr_seen++;
            if (|word_vld)
                chk("R6 lanes in lockstep", word_vld == '1, word_vld, 2'b11);
            for (int s = 0; s < NSEG; s++) begin
                if (word_vld[s]) begin
                    words_seen++;
                    if (exp_q[s].size() == 0) begin
                        chk("R5 unexpected word", 1'b0, word_data[s*WORD_W +: WORD_W], 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q[s].pop_front();
                        chk("R5 word data", word_data[s*WORD_W +: WORD_W] == e[23:0],
                            word_data[s*WORD_W +: WORD_W], e[23:0]);
                        chk("R6 channel index", 32'(word_ch) == 32'(e[31:24]), word_ch, e[31:24]);
                    end
                end
            end
        end
    end

    task automatic drain();
        while (exp_q[0].size() != 0 || exp_q[NSEG-1].size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic spi_start();
        @(negedge clk);
        drdy_n = 1'b0;
        spi_ld = 1'b1;
        @(negedge clk);
        spi_ld = 1'b0;
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    initial begin
        int r0, f0, o0, w0;
        repeat (4) @(negedge clk);
        // R4 reset state
        chk("R4 reset sclk", sclk == 1'b0, sclk, 0);
        chk("R3 reset fsync", fsync == 1'b0, fsync, 0);
        chk("R5 reset word_vld", word_vld == '0, word_vld, 0);
        chk("R7 reset overrun", overrun == 1'b0, overrun, 0);
        // R8 mode limits
        chk("R8 high-speed limit", max_chain_ch(SPD_HIGH) == 10, max_chain_ch(SPD_HIGH), 10);
        chk("R8 high-res limit", max_chain_ch(SPD_HIRES) == 21, max_chain_ch(SPD_HIRES), 21);
        chk("R8 low-power div0 limit", max_chain_ch(SPD_LOWPWR_DIV0) == 10, max_chain_ch(SPD_LOWPWR_DIV0), 10);
        chk("R8 low-speed div1 limit", max_chain_ch(SPD_LOWSPD_DIV1) == 106, max_chain_ch(SPD_LOWSPD_DIV1), 106);
        rst = 1'b0;

        // R2 data-ready readout, code 000
        fmt = 3'b000;
        r0 = sclk_rises; f0 = fs_rises; o0 = ovr_seen; w0 = words_seen;
        spi_start();
        drain();
        chk("R4 rising edges per readout", sclk_rises - r0 == SEG_BITS, sclk_rises - r0, SEG_BITS);
        chk("R2 no fsync in data-ready protocol", fs_rises == f0, fs_rises - f0, 0);
        chk("R5 word count", words_seen - w0 == NSEG * SEG_CH, words_seen - w0, NSEG * SEG_CH);
        chk("R7 no overrun on clean read", ovr_seen == o0, ovr_seen - o0, 0);
        chk("R4 sclk idle after readout", sclk == 1'b0, sclk, 0);

        // R1 code 001 also selects data-ready protocol
        fmt = 3'b001;
        r0 = sclk_rises;
        spi_start();
        drain();
        chk("R1 code 001 reads", sclk_rises - r0 == SEG_BITS, sclk_rises - r0, SEG_BITS);

        // R7 second data-ready during shift
        o0 = ovr_seen; w0 = words_seen; r0 = sclk_rises;
        spi_start();
        repeat (300) @(negedge clk);
        drdy_n = 1'b0;
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
        drain();
        chk("R7 one overrun pulse", ovr_seen - o0 == 1, ovr_seen - o0, 1);
        chk("R7 readout unchanged", words_seen - w0 == NSEG * SEG_CH, words_seen - w0, NSEG * SEG_CH);
        chk("R7 no restarted shift", sclk_rises - r0 == SEG_BITS, sclk_rises - r0, SEG_BITS);

        // R1 reserved codes ignore data-ready
        for (int k = 0; k < 3; k++) begin
            fmt = (k == 0) ? 3'b010 : (k == 1) ? 3'b101 : 3'b111;
            r0 = sclk_rises; f0 = fs_rises; o0 = ovr_seen; w0 = words_seen;
            @(negedge clk); drdy_n = 1'b0;
            repeat (5) @(negedge clk); drdy_n = 1'b1;
            repeat (200) @(negedge clk);
            chk("R1 reserved code no sclk", sclk_rises == r0, sclk_rises - r0, 0);
            chk("R1 reserved code no fsync", fs_rises == f0, fs_rises - f0, 0);
            chk("R1 reserved code no words", words_seen == w0 && ovr_seen == o0, words_seen - w0, 0);
        end

        // R3 frame-sync readouts, code 011
        frame_cyc = 16'd1800;
        r0 = sclk_rises; f0 = fs_rises; o0 = ovr_seen;
        fmt = 3'b011;
        while (fs_rises - f0 < 2) @(negedge clk);
        fmt = 3'b111;
        drain();
        chk("R3 frame period", fs_gap == 1800, fs_gap, 1800);
        chk("R3 two frames read", sclk_rises - r0 == 2 * SEG_BITS, sclk_rises - r0, 2 * SEG_BITS);
        chk("R7 no overrun with long frame", ovr_seen == o0, ovr_seen - o0, 0);

        // R7 frame period shorter than a readout, code 100
        frame_cyc = 16'd900;
        r0 = sclk_rises; f0 = fs_rises; o0 = ovr_seen;
        fmt = 3'b100;
        repeat (4000) @(negedge clk);
        fmt = 3'b111;
        drain();
        chk("R7 frame overrun flagged", ovr_seen - o0 >= 2, ovr_seen - o0, 2);
        chk("R7 frames dropped on overrun", fs_rises - f0 == 2, fs_rises - f0, 2);
        chk("R3 one readout per frame pulse", sclk_rises - r0 == (fs_rises - f0) * SEG_BITS,
            sclk_rises - r0, (fs_rises - f0) * SEG_BITS);

        finish_run();
    end

endmodule